// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the directions of the most recently resolved branches. It XORs that history with a field of the branch address, and the result selects one entry of a table of 2-bit saturating counters. The upper bit of the selected counter is the prediction. The lookup path is combinational: the fetch side presents an address and reads back, in the same cycle, a direction, the table index it used and the current history.

The fetch side keeps the history value it read at lookup time. When the branch resolves, that value comes back on the resolve port together with the branch address and the real direction. The block rebuilds the index from the address and the returned history, trains that counter, and shifts the real direction into the history register. Because the index is rebuilt from the returned history, the write lands on the same entry the prediction used, even if the live history has moved on since then.

Top module: `gshare_predictor`

## Requirements
- R1: While `rst_ni` is low and after it is released, the history register reads all zeros and every counter holds weakly-taken (`2'b10`). As a result, every lookup predicts taken until the first training write.
- R2: On a clock edge with `upd_valid_i` high, `hist_o` becomes `{hist_o[HIST_W-2:0], upd_taken_i}`, so the newest direction enters at bit 0 and the oldest leaves at the top. Without `upd_valid_i` the history holds.
- R3: `pred_idx_o` equals `hist_o` XOR the `PC_BITS`-wide address field starting at bit `PC_LSB` of `lkp_pc_i`, with the field zero-extended to `HIST_W` bits. The table has 2^`HIST_W` entries.
- R4: `pred_taken_o` is the upper bit of the selected counter, so the states `11` and `10` mean taken and `01` and `00` mean not taken.
- R5: A taken resolve increments the trained counter, and the counter saturates at `11`.
- R6: A not-taken resolve decrements the trained counter, and the counter saturates at `00`.
- R7: A counter in a strong state changes its prediction only after two consecutive opposing outcomes.
- R8: The trained entry is `upd_hist_i` XOR the address field of `upd_pc_i`, and never the entry the live history would select. No other entry changes.
- R9: When a lookup and a training write address the same entry in the same cycle, the lookup returns the value from before the write. The new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_pc_i | input | ADDR_W | Address of the branch being looked up |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | HIST_W | Table index used by the lookup |
| hist_o | output | HIST_W | Current global history; bit 0 is the newest outcome |
| upd_valid_i | input | 1 | A branch resolves this cycle |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_hist_i | input | HIST_W | History value captured when the branch was predicted |

## Verification
The bench builds the block with a 4-bit history and 4 address bits, which gives a 16-entry table with a full-width XOR. With that configuration the bench can choose a lookup address that reaches any entry under any live history. This lets it sweep the whole reset state, walk single counters through both saturation limits and the two-miss flip, and compare an entry trained through a stale history value against the entry the live history would have picked. The same-cycle lookup-and-write collision is driven on a single entry, and the bench samples that entry just before the write edge and again just after it.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  function automatic ctr_t ctr_next(ctr_t cur, logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 8,
  parameter int PC_BITS = 8,
  parameter int PC_LSB  = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [HIST_W-1:0] idx_o
);
  localparam int PAD = HIST_W - PC_BITS;

  logic [HIST_W-1:0] pc_ext;
  logic              unused_pc;

  // only the selected address field feeds the hash
  assign unused_pc = ^pc_i;

  if (PAD == 0) begin : g_full
    assign pc_ext = pc_i[PC_LSB +: PC_BITS];
  end else begin : g_pad
    assign pc_ext = {{PAD{1'b0}}, pc_i[PC_LSB +: PC_BITS]};
  end

  assign idx_o = hist_i ^ pc_ext;
endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output ctr_t               rd_cnt_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_taken_i,
  output logic [2*DEPTH-1:0] flat_o
);
  ctr_t cnt_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[g] <= CTR_WEAK_T;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        cnt_q[g] <= ctr_next(cnt_q[g], wr_taken_i);
    end
    assign flat_o[2*g +: 2] = cnt_q[g];
  end

  // read sees the stored value, so a same-cycle write is not forwarded
  assign rd_cnt_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 8,
  parameter int PC_BITS = 8,
  parameter int PC_LSB  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] pred_idx_o,
  output logic [HIST_W-1:0] hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int DEPTH = 1 << HIST_W;

  logic [HIST_W-1:0]  hist;
  logic [HIST_W-1:0]  lkp_idx;
  logic [HIST_W-1:0]  upd_idx;
  ctr_t               lkp_cnt;
  logic [2*DEPTH-1:0] cnt_flat;

  gshare_history #(.HIST_W(HIST_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist)
  );

  gshare_index #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS), .PC_LSB(PC_LSB)
  ) u_lkp_idx (
    .pc_i  (lkp_pc_i),
    .hist_i(hist),
    .idx_o (lkp_idx)
  );

  // training index rebuilt from the snapshot, not the live history
  gshare_index #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS), .PC_LSB(PC_LSB)
  ) u_upd_idx (
    .pc_i  (upd_pc_i),
    .hist_i(upd_hist_i),
    .idx_o (upd_idx)
  );

  gshare_table #(.IDX_W(HIST_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lkp_idx),
    .rd_cnt_o  (lkp_cnt),
    .wr_en_i   (upd_valid_i),
    .wr_idx_i  (upd_idx),
    .wr_taken_i(upd_taken_i),
    .flat_o    (cnt_flat)
  );

  assign pred_taken_o = lkp_cnt[1];
  assign pred_idx_o   = lkp_idx;
  assign hist_o       = hist;
endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 8,
  localparam int DEPTH = 1 << HIST_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  lkp_pc_i,
  input logic               pred_taken_o,
  input logic [HIST_W-1:0]  hist_o,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [HIST_W-1:0]  upd_idx,
  input logic [2*DEPTH-1:0] cnt_flat
);
  logic              wr_q, tk_q, vld_q, pred_q;
  logic [HIST_W-1:0] idx_q;
  logic [1:0]        old_q, now_cnt;
  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b0; tk_q <= 1'b0; idx_q <= '0; old_q <= 2'b10;
      vld_q <= 1'b1; pc_q <= '0; pred_q <= 1'b0;
    end else begin
      wr_q   <= upd_valid_i;
      tk_q   <= upd_taken_i;
      idx_q  <= upd_idx;
      old_q  <= cnt_flat[{upd_idx, 1'b0} +: 2];
      vld_q  <= upd_valid_i;
      pc_q   <= lkp_pc_i;
      pred_q <= pred_taken_o;
    end
  end

  assign now_cnt = cnt_flat[{idx_q, 1'b0} +: 2];

  a_r2_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(upd_taken_i)});

  a_r2_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_o));

  a_r5_sat_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && tk_q) |-> now_cnt == ((old_q == 2'b11) ? 2'b11 : old_q + 2'd1));

  a_r6_sat_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && !tk_q) |-> now_cnt == ((old_q == 2'b00) ? 2'b00 : old_q - 2'd1));

  a_r8_quiet_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_q && lkp_pc_i == pc_q) |-> pred_taken_o == pred_q);
endmodule

bind gshare_predictor gshare_predictor_chk #(
  .ADDR_W(ADDR_W), .HIST_W(HIST_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_pc_i    (lkp_pc_i),
  .pred_taken_o(pred_taken_o),
  .hist_o      (hist_o),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .upd_idx     (upd_idx),
  .cnt_flat    (cnt_flat)
);

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb_top;
  localparam int ADDR_W  = 16;
  localparam int HIST_W  = 4;
  localparam int PC_BITS = 4;
  localparam int PC_LSB  = 2;
  localparam int DEPTH   = 1 << HIST_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lkp_pc_i = '0;
  logic              pred_taken_o;
  logic [HIST_W-1:0] pred_idx_o, hist_o;
  logic              upd_valid_i = 1'b0;
  logic [ADDR_W-1:0] upd_pc_i = '0;
  logic              upd_taken_i = 1'b0;
  logic [HIST_W-1:0] upd_hist_i = '0;

  int checks = 0, errors = 0;
  int mdl [DEPTH];
  logic [HIST_W-1:0] mhist;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gshare_predictor #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS), .PC_LSB(PC_LSB)
  ) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] pc_for(logic [HIST_W-1:0] e, logic [HIST_W-1:0] h);
    return ADDR_W'(e ^ h) << PC_LSB;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    upd_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 2;
    mhist = '0;
    @(negedge clk_i);
  endtask

  function automatic void mdl_train(logic [HIST_W-1:0] e, logic tk);
    if (tk) mdl[e] = (mdl[e] == 3) ? 3 : mdl[e] + 1;
    else    mdl[e] = (mdl[e] == 0) ? 0 : mdl[e] - 1;
    mhist = {mhist[HIST_W-2:0], tk};
  endfunction

  // train entry e using history snapshot snap
  task automatic train(logic [HIST_W-1:0] e, logic [HIST_W-1:0] snap, logic tk);
    @(negedge clk_i);
    upd_valid_i = 1'b1;
    upd_pc_i    = pc_for(e, snap);
    upd_hist_i  = snap;
    upd_taken_i = tk;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    mdl_train(e, tk);
  endtask

  task automatic probe(string req, logic [HIST_W-1:0] e);
    lkp_pc_i = pc_for(e, mhist);
    #1;
    chk({req, " idx (R3)"}, int'(pred_idx_o), int'(e));
    chk({req, " dir (R4)"}, int'(pred_taken_o), mdl[e] >= 2 ? 1 : 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 history", int'(hist_o), 0);
    for (int e = 0; e < DEPTH; e++) begin
      lkp_pc_i = pc_for(HIST_W'(e), '0);
      #1;
      chk("R1 weak taken", int'(pred_taken_o), 1);
      chk("R3 idx at reset", int'(pred_idx_o), e);
    end
  endtask

  task automatic t_shift();
    do_reset();
    train(4'd1, mhist, 1'b1);
    train(4'd1, mhist, 1'b1);
    train(4'd1, mhist, 1'b1);
    train(4'd1, mhist, 1'b0);
    #1 chk("R2 TTTN", int'(hist_o), 4'b1110);
    train(4'd2, mhist, 1'b1);
    #1 chk("R2 TTNT", int'(hist_o), 4'b1101);
    repeat (3) @(negedge clk_i);
    chk("R2 hold idle", int'(hist_o), 4'b1101);
    probe("R3 after shifts", 4'd7);
    probe("R3 after shifts", 4'd1);
  endtask

  task automatic t_sat_up();
    do_reset();
    train(4'd5, 4'd3, 1'b1);
    train(4'd5, 4'd3, 1'b1);
    train(4'd5, 4'd3, 1'b1);
    probe("R5 saturate 11", 4'd5);
    chk("R5 model strong", mdl[5], 3);
    train(4'd5, 4'd3, 1'b0);
    probe("R7 first miss keeps taken", 4'd5);
    chk("R7 still taken", int'(pred_taken_o), 1);
    train(4'd5, 4'd3, 1'b0);
    probe("R7 second miss flips", 4'd5);
    chk("R7 flipped", int'(pred_taken_o), 0);
  endtask

  task automatic t_sat_down();
    do_reset();
    train(4'd9, 4'd0, 1'b0);
    train(4'd9, 4'd0, 1'b0);
    train(4'd9, 4'd0, 1'b0);
    probe("R6 saturate 00", 4'd9);
    chk("R6 not taken", int'(pred_taken_o), 0);
    train(4'd9, 4'd0, 1'b1);
    probe("R6 01 after one taken", 4'd9);
    chk("R6 stays not taken", int'(pred_taken_o), 0);
  endtask

  task automatic t_snapshot();
    logic [HIST_W-1:0] live_e;
    do_reset();
    train(4'd0, 4'd0, 1'b1);
    train(4'd0, 4'd0, 1'b1);
    train(4'd0, 4'd0, 1'b1);
    // mhist now 0111; snapshot 1010 aims at entry 12 with pc field 0110
    live_e = 4'b0110 ^ mhist;
    train(4'd12, 4'b1010, 1'b0);
    train(4'd12, 4'b1010, 1'b0);
    probe("R8 snapshot entry trained", 4'd12);
    chk("R8 snapshot entry nt", int'(pred_taken_o), 0);
    probe("R8 live entry untouched", live_e);
    chk("R8 live entry taken", int'(pred_taken_o), 1);
    probe("R8 neighbour untouched", 4'd13);
    chk("R8 neighbour taken", int'(pred_taken_o), 1);
  endtask

  task automatic t_collide();
    logic [HIST_W-1:0] e;
    do_reset();
    e = 4'd6;
    @(negedge clk_i);
    lkp_pc_i    = pc_for(e, mhist);
    upd_valid_i = 1'b1;
    upd_pc_i    = pc_for(e, mhist);
    upd_hist_i  = mhist;
    upd_taken_i = 1'b0;
    #1;
    chk("R9 pre-write value", int'(pred_taken_o), 1);
    chk("R9 idx same entry", int'(pred_idx_o), int'(e));
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    mdl_train(e, 1'b0);
    probe("R9 post-write value", e);
    chk("R9 now not taken", int'(pred_taken_o), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shift();
    t_sat_up();
    t_sat_down();
    t_snapshot();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule